// File: doc/BRIEF.md
# Serial Register-Access Slave Interface

This block lets a host reach a small bank of internal registers over a synchronous four-pin serial link. Every exchange has two phases. The host first writes a one-byte command into the command register. That byte selects the direction and the target of the next phase. The second phase moves the target register's bits in or out. When that phase ends, the interface waits for a new command.

Conversion results from two converter channels (main and auxiliary) arrive on a valid/ready stream. Each accepted result passes through a short update pipeline into a 24-bit read-only data register. An active-low data-ready pin drops when a fresh result sits in that register. It rises again when a full read of the data register completes. It also rises for at least one system clock before the register is overwritten. A status register holds one sticky bit per channel, so a host that keeps chip select tied low can poll for readiness.

The serial clock idles high. The block samples input on its rising edge and changes output on its falling edge, MSB first. It samples the pins with the system clock through two-stage synchronisers. The serial clock must therefore stay well below half the system clock rate. Chip select can frame each transfer, can be tied low for three-wire use, or can act as a frame sync whose falling edge presents the first output bit.

Top module: `sio_reg_slave`

## Requirements
- R1: After reset, drdy_n is 1, sdo is 0, res_ready is 1, both control registers and the status register read 0, and the interface waits for a command byte.
- R2: Command byte layout: bit 7 must be 0, bit 6 is 1 for read and 0 for write, and bits 3:0 hold the address. A byte with bit 7 set is discarded, and the byte that follows is taken as a command again.
- R3: Addresses 1 and 2 are 8-bit control registers. A write phase stores the 8 received bits, and a read phase returns them MSB first.
- R4: Address 0 is the 8-bit status register and address 4 is the 24-bit data register; both are read-only, and writes to them change nothing. Any other address takes 8 bits, ignores writes and reads back 0.
- R5: When a result is accepted on the stream (res_valid and res_ready high at a clock edge), drdy_n is 1 in the following cycle and the data register loads one cycle later. From that cycle on, drdy_n is 0.
- R6: Completing all 24 bits of a data-register read sets drdy_n to 1 and clears both status bits. A second read before the next update returns the same value.
- R7: Status bit 0 is set when a main-channel result (res_chan = 0) loads, and bit 1 is set when an auxiliary-channel result (res_chan = 1) loads. The data register always holds the most recent result.
- R8: res_ready is 0 while an update is pending and while a data-register read phase is in progress. The source must hold res_valid, res_chan and res_data steady until it is accepted.
- R9: While cs_n is high, serial clock edges are ignored. Raising cs_n after part of a byte or register has shifted abandons the transfer, and the interface waits for a command.
- R10: Raising cs_n exactly at the end of a read command keeps the pending read; sdo is 0 while cs_n is high. When cs_n falls again, sdo presents the MSB of the selected register before any serial clock edge.
- R11: With cs_n held low throughout, back-to-back command and data phases run without any framing.
- R12: sdo changes only after a falling serial clock edge (or a change of cs_n); sdi is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select / frame sync |
| sclk | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| drdy_n | output | 1 | Active-low data-ready |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_chan | input | 1 | Result channel, 0 main, 1 auxiliary |
| res_data | input | 24 | Result value |

## Verification
The register path is exercised with distinct bit patterns (0xA5, 0x3C and three 24-bit results). These patterns reveal bit-order errors, off-by-one shifting and cross-wired addresses. Writes to read-only and unused addresses, and a command with bit 7 set, show whether stray writes are dropped and command framing is kept. Results are pushed on both channels, with and without an intervening read, to tell per-channel status bits apart from a single shared flag. One result is pushed during a data read, which shows whether back-pressure stops it from overwriting the value being shifted out. The three chip-select usages are run in turn: tied low, framing with a mid-byte abort and ignored clocks, and frame sync with the MSB visible before the first clock edge.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  localparam int CMD_BITS      = 8;
  localparam int CMD_BAD_BIT   = 7;
  localparam int CMD_READ_BIT  = 6;

  localparam int ADDR_STATUS   = 0;
  localparam int ADDR_CTRL0    = 1;
  localparam int NUM_CTRL      = 2;
  localparam int ADDR_DATA     = 4;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/sio_serial_fsm.sv
module sio_serial_fsm
  import sio_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] peek_addr,
  input  logic [DATA_W-1:0] peek_val,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_active,
  output logic              rd_is_data,
  output logic              rd_done,
  output logic              fall_p,
  output logic              sdo
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int PAD   = DATA_W - CTRL_W;

  phase_e              phase;
  logic [CNT_W-1:0]    cnt;
  logic [DATA_W-1:0]   shin;
  logic [DATA_W-1:0]   shout;
  logic [ADDR_W-1:0]   addr_q;
  logic                armed;
  logic                sclk_q;
  logic                rise_p;
  logic [CMD_BITS-1:0] cmd_byte;
  logic [CNT_W-1:0]    last_idx;

  function automatic logic [CNT_W-1:0] bits_for(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(ADDR_DATA)) ? CNT_W'(DATA_W) : CNT_W'(CTRL_W);
  endfunction

  assign rise_p    = sclk_s & ~sclk_q & ~cs_n_s;
  assign fall_p    = ~sclk_s & sclk_q & ~cs_n_s;
  assign cmd_byte  = {shin[CMD_BITS-2:0], sdi_s};
  assign peek_addr = cmd_byte[ADDR_W-1:0];
  assign last_idx  = bits_for(addr_q) - CNT_W'(1);

  assign rd_active  = (phase == PH_RD);
  assign rd_is_data = rd_active && (addr_q == ADDR_W'(ADDR_DATA));
  assign sdo        = (rd_active && !cs_n_s) ? shout[DATA_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      shin    <= '0;
      shout   <= '0;
      addr_q  <= '0;
      armed   <= 1'b0;
      sclk_q  <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_done <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      wr_en   <= 1'b0;
      rd_done <= 1'b0;
      if (cs_n_s) begin
        if (cnt != '0) begin
          phase <= PH_CMD;
          cnt   <= '0;
        end
        armed <= 1'b0;
      end else if (rise_p) begin
        shin <= {shin[DATA_W-2:0], sdi_s};
        unique case (phase)
          PH_CMD: begin
            if (cnt == CNT_W'(CMD_BITS - 1)) begin
              cnt <= '0;
              if (!cmd_byte[CMD_BAD_BIT]) begin
                addr_q <= peek_addr;
                if (cmd_byte[CMD_READ_BIT]) begin
                  phase <= PH_RD;
                  armed <= 1'b0;
                  shout <= (peek_addr == ADDR_W'(ADDR_DATA)) ? peek_val
                                                             : (peek_val << PAD);
                end else begin
                  phase <= PH_WR;
                end
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_WR: begin
            if (cnt == last_idx) begin
              cnt     <= '0;
              phase   <= PH_CMD;
              wr_en   <= 1'b1;
              wr_addr <= addr_q;
              wr_data <= {shin[DATA_W-2:0], sdi_s};
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_RD: begin
            armed <= 1'b1;
            if (cnt == last_idx) begin
              cnt     <= '0;
              phase   <= PH_CMD;
              rd_done <= (addr_q == ADDR_W'(ADDR_DATA));
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: phase <= PH_CMD;
        endcase
      end else if (fall_p && rd_active && armed) begin
        shout <= {shout[DATA_W-2:0], 1'b0};
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 8,
  parameter int ADDR_W = 4,
  parameter int NCHAN  = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_val,
  input  logic              rd_is_data,
  input  logic              rd_done,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              drdy_n,
  output logic [NCHAN-1:0]  stat_bits
);

  logic [CTRL_W-1:0] ctrl_q [NUM_CTRL];
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] stage_q;
  logic [CH_W-1:0]   stage_ch;
  logic              pend;
  logic              fresh;
  logic              accept;

  assign res_ready = !pend && !rd_is_data;
  assign accept    = res_valid && res_ready;
  assign drdy_n    = !fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRL; i++) ctrl_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (wr_addr == ADDR_W'(ADDR_CTRL0 + i)) ctrl_q[i] <= wr_data[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      stage_q   <= '0;
      stage_ch  <= '0;
      pend      <= 1'b0;
      fresh     <= 1'b0;
      stat_bits <= '0;
    end else begin
      if (rd_done) begin
        fresh     <= 1'b0;
        stat_bits <= '0;
      end
      if (accept) begin
        fresh    <= 1'b0;
        pend     <= 1'b1;
        stage_q  <= res_data;
        stage_ch <= res_chan;
      end
      if (pend) begin
        pend                <= 1'b0;
        data_q              <= stage_q;
        fresh               <= 1'b1;
        stat_bits[stage_ch] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_addr == ADDR_W'(ADDR_STATUS)) rd_val = DATA_W'(stat_bits);
    if (rd_addr == ADDR_W'(ADDR_DATA))   rd_val = data_q;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == ADDR_W'(ADDR_CTRL0 + i)) rd_val = DATA_W'(ctrl_q[i]);
  end

endmodule

// File: rtl/sio_reg_slave.sv
module sio_reg_slave
  import sio_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CTRL_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int NCHAN   = 2,
  parameter int SYNC_N  = 2,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              drdy_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data
);

  logic              cs_n_s;
  logic              sclk_s;
  logic              sdi_s;
  logic [ADDR_W-1:0] peek_addr;
  logic [DATA_W-1:0] peek_val;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_active;
  logic              rd_is_data;
  logic              rd_done;
  logic              fall_p;
  logic [NCHAN-1:0]  stat_bits;

  sio_sync #(
    .W       (3),
    .STAGES  (SYNC_N),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, sdi}),
    .q     ({cs_n_s, sclk_s, sdi_s})
  );

  sio_serial_fsm #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .ADDR_W (ADDR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .peek_addr  (peek_addr),
    .peek_val   (peek_val),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_active  (rd_active),
    .rd_is_data (rd_is_data),
    .rd_done    (rd_done),
    .fall_p     (fall_p),
    .sdo        (sdo)
  );

  sio_reg_file #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .ADDR_W (ADDR_W),
    .NCHAN  (NCHAN),
    .CH_W   (CH_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (peek_addr),
    .rd_val     (peek_val),
    .rd_is_data (rd_is_data),
    .rd_done    (rd_done),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_chan   (res_chan),
    .res_data   (res_data),
    .drdy_n     (drdy_n),
    .stat_bits  (stat_bits)
  );

endmodule

// File: rtl/sio_reg_slave_chk.sv
module sio_reg_slave_chk #(
  parameter int NCHAN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic             drdy_n,
  input logic             sdo,
  input logic             cs_n_s,
  input logic             rd_active,
  input logic             rd_is_data,
  input logic             rd_done,
  input logic             fall_p,
  input logic [NCHAN-1:0] stat_bits
);

  // R5: an accepted result forces data-ready inactive in the next cycle
  p_pre_update_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> drdy_n);

  // R5: data-ready only becomes active two cycles after an acceptance
  p_load_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(res_valid && res_ready, 2));

  // R8: no result is taken while the data register is being shifted out
  p_hold_off_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_data |-> !res_ready);

  // R6: a finished data read leaves data-ready inactive and status clear
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (drdy_n && (stat_bits == '0)));

  // R12: inside a read phase the output moves only after a falling edge
  p_sdo_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && !$past(fall_p) && $stable(cs_n_s))
      |-> $stable(sdo));

endmodule

bind sio_reg_slave sio_reg_slave_chk #(.NCHAN(NCHAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .drdy_n     (drdy_n),
  .sdo        (sdo),
  .cs_n_s     (cs_n_s),
  .rd_active  (rd_active),
  .rd_is_data (rd_is_data),
  .rd_done    (rd_done),
  .fall_p     (fall_p),
  .stat_bits  (stat_bits)
);

// File: tb/tb_sio_reg_slave.sv
`timescale 1ns/1ps
module tb_sio_reg_slave;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        drdy_n;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [0:0]  res_chan = 1'b0;
  logic [23:0] res_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference model
  int   ctrl_m [int];
  int   data_m = 0;
  int   stat_m = 0;
  logic mdl_drdy = 1'b1;
  bit   chk_en = 1'b0;

  always #5 clk = ~clk;

  sio_reg_slave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .sdo       (sdo),
    .drdy_n    (drdy_n),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_chan  (res_chan),
    .res_data  (res_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of data-ready against the model (R5, R6)
  always @(negedge clk) begin
    if (chk_en && rst_n && !done) check("R5/R6 drdy_n vs model", 32'(drdy_n), 32'(mdl_drdy));
  end

  function automatic int mdl_read(input int a);
    if (a == 0) return stat_m;
    if (a == 4) return data_m;
    if (ctrl_m.exists(a)) return ctrl_m[a];
    return 0;
  endfunction

  function automatic int width_of(input int a);
    return (a == 4) ? 24 : 8;
  endfunction

  task automatic xfer(input logic [23:0] tx, input int n, output logic [23:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdi  = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic reg_write(input int a, input logic [23:0] v);
    logic [23:0] junk;
    xfer(24'(a & 15), 8, junk);
    xfer(v, width_of(a), junk);
    if (a == 1 || a == 2) ctrl_m[a] = int'(v[7:0]);
  endtask

  task automatic reg_read(input int a, output logic [23:0] v);
    logic [23:0] junk;
    if (a == 4) chk_en = 1'b0;
    xfer(24'(8'h40 | a[7:0]), 8, junk);
    xfer(24'h0, width_of(a), v);
    if (a == 4) begin
      repeat (2) @(negedge clk);
      mdl_drdy = 1'b1;
      stat_m = 0;
      chk_en = 1'b1;
    end
  endtask

  task automatic read_expect(input int a, input string req);
    logic [23:0] v;
    int exp;
    exp = mdl_read(a);
    reg_read(a, v);
    check(req, 32'(v), 32'(exp));
  endtask

  task automatic push_result(input logic ch, input logic [23:0] d);
    chk_en = 1'b0;
    res_valid = 1'b1;
    res_chan = ch;
    res_data = d;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    check("R5 drdy_n high before update", 32'(drdy_n), 32'd1);
    check("R8 ready low while update pending", 32'(res_ready), 32'd0);
    @(negedge clk);
    check("R5 drdy_n low after load", 32'(drdy_n), 32'd0);
    data_m = int'(d);
    stat_m = stat_m | (1 << ch);
    mdl_drdy = 1'b0;
    chk_en = 1'b1;
  endtask

  initial begin
    logic [23:0] v;
    logic [23:0] junk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 drdy_n after reset", 32'(drdy_n), 32'd1);
    check("R1 sdo after reset", 32'(sdo), 32'd0);
    check("R1 res_ready after reset", 32'(res_ready), 32'd1);
    chk_en = 1'b1;
    read_expect(0, "R1 status after reset");
    read_expect(1, "R1 ctrl0 after reset");

    // R3 / R11 control registers, three-wire mode
    reg_write(1, 24'h0000A5);
    reg_write(2, 24'h00003C);
    read_expect(1, "R3 R11 ctrl0 readback");
    read_expect(2, "R3 R11 ctrl1 readback");

    // R4 read-only and unused addresses
    reg_write(0, 24'h0000FF);
    read_expect(0, "R4 status ignores write");
    reg_write(7, 24'h0000FF);
    read_expect(7, "R4 unused address reads zero");
    reg_write(4, 24'hFFFFFF);
    read_expect(4, "R4 data register ignores write");
    read_expect(1, "R4 ctrl0 untouched by other writes");

    // R2 command with bit 7 set is discarded
    xfer(24'h81, 8, junk);
    read_expect(1, "R2 bad command ignored");

    // R5 R6 R7 results
    push_result(1'b0, 24'h123456);
    read_expect(0, "R7 status main bit");
    check("R6 drdy_n kept by status read", 32'(drdy_n), 32'd0);
    read_expect(4, "R6 data read");
    check("R6 drdy_n after data read", 32'(drdy_n), 32'd1);
    read_expect(0, "R6 status cleared by data read");
    data_m = 32'h123456;
    read_expect(4, "R6 second read same value");
    push_result(1'b1, 24'hABCDEF);
    read_expect(0, "R7 status aux bit");
    push_result(1'b0, 24'h00FF00);
    read_expect(0, "R7 status both bits");

    // R8 back-pressure during a data read
    chk_en = 1'b0;
    fork
      begin
        xfer(24'h44, 8, junk);
        xfer(24'h0, 24, v);
      end
      begin
        repeat (12 * 2 * HALF) @(negedge clk);
        res_valid = 1'b1;
        res_chan = 1'b1;
        res_data = 24'h777777;
        check("R8 ready low during data read", 32'(res_ready), 32'd0);
        while (!res_ready) @(negedge clk);
        @(negedge clk);
        res_valid = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    check("R8 read returns value before update", 32'(v), 32'h00FF00);
    check("R8 drdy_n low after held result loads", 32'(drdy_n), 32'd0);
    data_m = 32'h777777;
    stat_m = 2;
    mdl_drdy = 1'b0;
    chk_en = 1'b1;
    read_expect(0, "R8 status after held result");
    read_expect(4, "R8 held result read");

    // R9 abort by chip select, ignored clocks
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(24'h02, 8, junk);
    xfer(24'h0F, 4, junk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    read_expect(2, "R9 aborted write left ctrl1");
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    read_expect(1, "R9 clocks ignored while deselected");

    // R10 frame sync: MSB on chip-select fall
    xfer(24'h41, 8, junk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R10 sdo quiet while deselected", 32'(sdo), 32'd0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 MSB shown on chip-select fall", 32'(sdo), 32'd1);
    xfer(24'h0, 8, v);
    check("R10 R12 frame-sync read", 32'(v), 32'hA5);
    read_expect(2, "R11 transfer after frame-sync read");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule